// File: doc/BRIEF.md
# Rate-Limited Fan Speed Ramp

This block turns target fan-speed writes into the 8-bit code that feeds a fan DAC. Software writes a target speed and a small ramp control register through a simple register write port. With ramping off, the target goes straight to the DAC code. With ramping on, an up/down counter moves the code toward the target by one LSB on each tick of a slow timebase, so the fan changes speed gradually and quietly.

The timebase is a prescaler on the system clock. It gives a 16 Hz base tick, which is then divided down to 8, 4 or 1 Hz by the rate field. An override input, driven by over-temperature logic elsewhere, forces the code to full scale at once, whatever the ramp is doing.

Top module: `fan_speed_ramp`

## Requirements
- R1: A synchronous reset clears the speed register, the ramp counter and the ramp control register to zero, so the DAC code and both read views are 0x00.
- R2: While ramp control bit 0 is clear, a write to the speed register (write address 0) appears on the DAC code on the clock edge that stores it.
- R3: Setting ramp control bit 0 (write address 1) does not change the DAC code: the counter already holds the present speed value.
- R4: While ramping, the DAC code moves toward the target by exactly one LSB per tick, up or down, and stays put once it equals the target.
- R5: Ramp control bits [2:1] choose the step rate: 00 steps every 16 base ticks (1 Hz), 01 every 4 (4 Hz), 10 every 2 (8 Hz), 11 on every base tick (16 Hz). A base tick lasts BASE_DIV clock cycles.
- R6: A new target written during a ramp is followed from the next tick on, reversing direction if it now lies on the other side of the current code.
- R7: While the override input is high, the DAC code is 0xFF in the same cycle, independent of the ramp state.
- R8: Reading the ramp control register (read address 1) returns bits [2:0] as written and zeros in bits [7:3]; read address 0 returns the speed register.
- R9: Clearing ramp control bit 0 during a ramp makes the DAC code equal the target on the clock edge that stores the write.
- R10: Between ticks the ramp counter does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write select: 0 speed, 1 ramp control |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 1 | Read select: 0 speed, 1 ramp control |
| rd_data | output | WIDTH | Read data for the selected register |
| force_full | input | 1 | Override to full-scale code |
| dac_code | output | WIDTH | Code for the fan DAC |

## Verification
The ramp is driven upward at each of the four rates from the same start point. The spacing measured between successive steps tells the rate encodings apart, and it also shows that nothing moves between ticks. A downward ramp and a mid-ramp target change below the current code show the count direction and the reversal. A small and a large value in bypass mode, together with enable and disable writes made during a ramp, separate the pass-through path from the counter path and show the preload and the snap.

// File: rtl/fan_ramp_pkg.sv
package fan_ramp_pkg;

   // Step-rate field encodings (ramp control bits [2:1])
   typedef enum logic [1:0] {
      RATE_1HZ  = 2'b00,
      RATE_4HZ  = 2'b01,
      RATE_8HZ  = 2'b10,
      RATE_16HZ = 2'b11
   } rate_sel_e;

   // Ramp control register image: rate in [2:1], enable in [0]
   typedef struct packed {
      rate_sel_e rate;
      logic      en;
   } ramp_ctrl_t;

   localparam int CTRL_BITS = $bits(ramp_ctrl_t);
   localparam int SUB_BITS  = 4;   // base ticks divided by up to 16

   localparam logic ADDR_SPEED = 1'b0;
   localparam logic ADDR_CTRL  = 1'b1;

   // Mask of sub-count bits that must all be set for a rate tick
   function automatic logic [SUB_BITS-1:0] rate_mask(rate_sel_e r);
      logic [SUB_BITS-1:0] m;
      case (r)
         RATE_1HZ:  m = 4'hF;
         RATE_4HZ:  m = 4'h3;
         RATE_8HZ:  m = 4'h1;
         default:   m = 4'h0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/fan_ramp_regs.sv
module fan_ramp_regs
   import fan_ramp_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_addr,
   output logic [WIDTH-1:0] rd_data,
   output logic [WIDTH-1:0] target_q,
   output ramp_ctrl_t       ctrl_q
);

   localparam int PAD = WIDTH - CTRL_BITS;

   always_ff @(posedge clk) begin
      if (rst) begin
         target_q <= '0;
         ctrl_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_SPEED)
            target_q <= wr_data;
         else
            ctrl_q   <= ramp_ctrl_t'(wr_data[CTRL_BITS-1:0]);
      end
   end

   // Reserved control bits always read back as zero
   always_comb begin
      if (rd_addr == ADDR_CTRL)
         rd_data = {{PAD{1'b0}}, ctrl_q};
      else
         rd_data = target_q;
   end

endmodule

// File: rtl/fan_ramp_tick.sv
module fan_ramp_tick
   import fan_ramp_pkg::*;
#(
   parameter int BASE_DIV = 7812500
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      run,
   input  rate_sel_e rate,
   output logic      tick
);

   localparam int PW = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
   localparam logic [PW-1:0] PRE_LAST = PW'(BASE_DIV - 1);

   logic [PW-1:0]       pre_q;
   logic [SUB_BITS-1:0] sub_q;
   logic [SUB_BITS-1:0] mask;
   logic                base_pulse;

   generate
      if (BASE_DIV < 2) begin : g_bad_div
         $error("fan_ramp_tick: BASE_DIV must be at least 2");
      end
   endgenerate

   assign base_pulse = run && (pre_q == PRE_LAST);
   assign mask       = rate_mask(rate);
   assign tick       = base_pulse && ((sub_q & mask) == mask);

   // Prescaler held at zero while the ramp is off, so tick phase starts
   // from the enabling write.
   always_ff @(posedge clk) begin
      if (rst || !run) begin
         pre_q <= '0;
         sub_q <= '0;
      end else begin
         pre_q <= base_pulse ? '0 : pre_q + 1'b1;
         if (base_pulse)
            sub_q <= sub_q + 1'b1;
      end
   end

   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick)
      else $error("tick on consecutive cycles");

   p_tick_needs_run_r10: assert property (@(posedge clk) disable iff (rst)
      !run |=> !tick)
      else $error("tick right after ramp disabled");

endmodule

// File: rtl/fan_ramp_counter.sv
module fan_ramp_counter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ramp_en,
   input  logic             tick,
   input  logic [WIDTH-1:0] target,
   output logic [WIDTH-1:0] count_q
);

   logic step_up, step_dn;

   assign step_up = ramp_en && tick && (count_q < target);
   assign step_dn = ramp_en && tick && (count_q > target);

   // With ramp off the counter tracks the target, which is the preload.
   always_ff @(posedge clk) begin
      if (rst)
         count_q <= '0;
      else if (!ramp_en)
         count_q <= target;
      else if (step_up)
         count_q <= count_q + 1'b1;
      else if (step_dn)
         count_q <= count_q - 1'b1;
   end

   p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
      ramp_en |=> (count_q == $past(count_q)) ||
                  (count_q == $past(count_q) + 1'b1) ||
                  (count_q == $past(count_q) - 1'b1))
      else $error("ramp moved more than one LSB");

   p_hold_at_goal_r4: assert property (@(posedge clk) disable iff (rst)
      (ramp_en && count_q == target) |=> $stable(count_q))
      else $error("counter left the target");

   p_still_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
      (ramp_en && !tick) |=> $stable(count_q))
      else $error("counter moved without tick");

   p_track_when_off_r9: assert property (@(posedge clk) disable iff (rst)
      !ramp_en |=> count_q == $past(target))
      else $error("counter not loaded from target");

endmodule

// File: rtl/fan_speed_ramp.sv
module fan_speed_ramp
   import fan_ramp_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int BASE_DIV = 7812500
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_addr,
   output logic [WIDTH-1:0] rd_data,
   input  logic             force_full,
   output logic [WIDTH-1:0] dac_code
);

   ramp_ctrl_t       ctrl;
   logic [WIDTH-1:0] target;
   logic [WIDTH-1:0] count;
   logic             tick;

   generate
      if (WIDTH < CTRL_BITS) begin : g_bad_width
         $error("fan_speed_ramp: WIDTH too small for control register");
      end
   endgenerate

   fan_ramp_regs #(.WIDTH(WIDTH)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .target_q (target),
      .ctrl_q   (ctrl)
   );

   fan_ramp_tick #(.BASE_DIV(BASE_DIV)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .run  (ctrl.en),
      .rate (ctrl.rate),
      .tick (tick)
   );

   fan_ramp_counter #(.WIDTH(WIDTH)) u_count (
      .clk     (clk),
      .rst     (rst),
      .ramp_en (ctrl.en),
      .tick    (tick),
      .target  (target),
      .count_q (count)
   );

   always_comb begin
      if (force_full)
         dac_code = '1;
      else if (ctrl.en)
         dac_code = count;
      else
         dac_code = target;
   end

   p_override_full_r7: assert property (@(posedge clk) disable iff (rst)
      force_full |-> (dac_code == {WIDTH{1'b1}}))
      else $error("override did not force full scale");

   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (count == '0) && (target == '0))
      else $error("reset left state nonzero");

endmodule

// File: tb/fan_speed_ramp_test.sv
module fan_speed_ramp_test;

   localparam int W  = 8;
   localparam int BD = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic         wr_en;
   logic         wr_addr;
   logic [W-1:0] wr_data;
   logic         rd_addr;
   logic [W-1:0] rd_data;
   logic         force_full;
   logic [W-1:0] dac_code;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   fan_speed_ramp #(.WIDTH(W), .BASE_DIV(BD)) uut (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .force_full (force_full),
      .dac_code   (dac_code)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input logic a, output logic [W-1:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // Follow a ramp to goal, checking direction, step size and spacing.
   task automatic ramp_watch(input logic [W-1:0] goal, input int period, input string req);
      logic [W-1:0] prev;
      logic [W-1:0] want;
      int c = 0;
      int last = -1;
      int limit;
      prev  = dac_code;
      limit = period * 300;
      while (dac_code != goal && c < limit) begin
         @(negedge clk);
         c++;
         if (dac_code != prev) begin
            want = (prev < goal) ? prev + 1'b1 : prev - 1'b1;
            check(dac_code == want, {req, " R4 unit step"}, dac_code, want);
            if (last >= 0)
               check(c - last == period, {req, " R10 step spacing"}, c - last, period);
            last = c;
            prev = dac_code;
         end
      end
      check(dac_code == goal, {req, " R4 reached goal"}, dac_code, goal);
      repeat (2 * period) @(negedge clk);
      check(dac_code == goal, {req, " R4 stopped at goal"}, dac_code, goal);
   endtask

   task automatic test_reset_r1();
      logic [W-1:0] v;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(dac_code == 8'h00, "R1 dac after reset", dac_code, 0);
      read_reg(1'b0, v);
      check(v == 8'h00, "R1 speed after reset", v, 0);
      read_reg(1'b1, v);
      check(v == 8'h00, "R1 ctrl after reset", v, 0);
      // reset in the middle of operation
      write_reg(1'b0, 8'h33);
      write_reg(1'b1, 8'h07);
      write_reg(1'b0, 8'h50);
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(dac_code == 8'h00, "R1 dac after mid reset", dac_code, 0);
      read_reg(1'b1, v);
      check(v == 8'h00, "R1 ctrl after mid reset", v, 0);
   endtask

   task automatic test_bypass_r2();
      write_reg(1'b0, 8'h5A);
      check(dac_code == 8'h5A, "R2 bypass write", dac_code, 8'h5A);
      write_reg(1'b0, 8'h10);
      check(dac_code == 8'h10, "R2 bypass second write", dac_code, 8'h10);
      write_reg(1'b0, 8'hF3);
      check(dac_code == 8'hF3, "R2 bypass large write", dac_code, 8'hF3);
   endtask

   task automatic test_enable_r3();
      write_reg(1'b0, 8'h20);
      write_reg(1'b1, 8'h01);
      check(dac_code == 8'h20, "R3 no jump on enable", dac_code, 8'h20);
      repeat (20 * BD) @(negedge clk);
      check(dac_code == 8'h20, "R3 steady after enable", dac_code, 8'h20);
   endtask

   task automatic test_rate_r5(input logic [1:0] code, input int div);
      write_reg(1'b1, 8'h00);
      write_reg(1'b0, 8'h20);
      write_reg(1'b1, {5'b0, code, 1'b1});
      write_reg(1'b0, 8'h24);
      ramp_watch(8'h24, div * BD, $sformatf("R5 rate %0d", code));
   endtask

   task automatic test_down_r4();
      write_reg(1'b0, 8'h1E);
      ramp_watch(8'h1E, BD, "R4 downward");
   endtask

   task automatic test_reverse_r6();
      int c = 0;
      write_reg(1'b1, 8'h00);
      write_reg(1'b0, 8'h20);
      write_reg(1'b1, 8'h07);
      write_reg(1'b0, 8'h30);
      while (dac_code != 8'h23 && c < 200) begin
         @(negedge clk);
         c++;
      end
      check(dac_code == 8'h23, "R6 ramp under way", dac_code, 8'h23);
      write_reg(1'b0, 8'h21);
      ramp_watch(8'h21, BD, "R6 reversal");
   endtask

   task automatic test_snap_r9();
      int c = 0;
      write_reg(1'b1, 8'h01);
      write_reg(1'b0, 8'h40);
      while (dac_code != 8'h22 && c < 400) begin
         @(negedge clk);
         c++;
      end
      check(dac_code == 8'h22, "R9 ramp started", dac_code, 8'h22);
      write_reg(1'b1, 8'h00);
      check(dac_code == 8'h40, "R9 snap on disable", dac_code, 8'h40);
   endtask

   task automatic test_override_r7();
      @(negedge clk);
      force_full = 1'b1;
      #1;
      check(dac_code == 8'hFF, "R7 override in bypass", dac_code, 8'hFF);
      @(negedge clk);
      force_full = 1'b0;
      #1;
      check(dac_code == 8'h40, "R7 release override", dac_code, 8'h40);
      write_reg(1'b1, 8'h07);
      write_reg(1'b0, 8'h10);
      repeat (BD + 1) @(negedge clk);
      force_full = 1'b1;
      #1;
      check(dac_code == 8'hFF, "R7 override mid ramp", dac_code, 8'hFF);
      @(negedge clk);
      force_full = 1'b0;
      write_reg(1'b1, 8'h00);
   endtask

   task automatic test_reserved_r8();
      logic [W-1:0] v;
      write_reg(1'b1, 8'hFF);
      read_reg(1'b1, v);
      check(v == 8'h07, "R8 reserved bits zero", v, 8'h07);
      write_reg(1'b1, 8'h0A);
      read_reg(1'b1, v);
      check(v == 8'h02, "R8 ctrl readback", v, 8'h02);
      write_reg(1'b1, 8'h00);
      write_reg(1'b0, 8'h9C);
      read_reg(1'b0, v);
      check(v == 8'h9C, "R8 speed readback", v, 8'h9C);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
      rd_addr = 1'b0; force_full = 1'b0;
      test_reset_r1();
      test_bypass_r2();
      test_enable_r3();
      test_rate_r5(2'b00, 16);
      test_rate_r5(2'b01, 4);
      test_rate_r5(2'b10, 2);
      test_rate_r5(2'b11, 1);
      test_down_r4();
      test_reverse_r6();
      test_snap_r9();
      test_override_r7();
      test_reserved_r8();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule